// File: doc/BRIEF.md
# Boot ROM Overlay Address Decoder

This block sits beside the processor of a small 8-bit board that has a 16-bit memory space and an 8-bit I/O space. For every memory cycle it picks exactly one target: RAM, a 2 KiB bootstrap/diagnostic ROM, a 2 KiB monitor ROM, or nothing. It also works out the address inside the ROM image. For every I/O cycle it picks the interval timer, one of two console serial devices, or nothing. Any access that hits nothing is flagged, and the value that the read should return is supplied with the flag.

Software controls where the boot ROM appears by writing a single write-only control port. That port drives an eight-bit latch in which each bit is addressed on its own. Both fields of the written byte are inverted: the value field and the bit-number field. Two of the latch bits choose among three layouts for the boot ROM. In the first, the ROM is mapped both at the bottom of memory and high in memory, so that a reset can start from either place. In the second, the ROM is mapped only high in memory. In the third, the ROM is switched out completely. Reset selects the first layout.

Top module: `boot_overlay_decoder`

## Requirements
- R1: A synchronous active-high reset clears all eight latch bits to 0. After reset, the boot ROM is therefore visible at 0000–07FF and at E800–EFFF.
- R2: A write to I/O port FF changes exactly one latch bit. The bit number is the complement of data bits 2..0, and the value stored is the complement of data bit 3. The change is visible after the clock edge. Any other cycle, including a write to any other port, leaves the latch unchanged.
- R3: `boot_sel_n` is latch bit 3 and `startup_n` is latch bit 5. Both are active low. All eight latch bits appear on `latch_q`, with bit i on `latch_q[i]`.
- R4: When `boot_sel_n`=0 and `startup_n`=0, addresses 0000–07FF and E800–EFFF select the boot ROM. `rom_addr` is then the address modulo 0x800.
- R5: When `boot_sel_n`=0 and `startup_n`=1, only E800–EFFF selects the boot ROM. Addresses 0000–07FF select RAM.
- R6: When `boot_sel_n`=1, the boot ROM is never selected. Addresses 0000–EFFF go to RAM where RAM exists, and are a miss elsewhere.
- R7: Addresses F800–FFFF always select the monitor ROM, whatever the latch holds. `rom_addr` is then 0x800 plus the address modulo 0x800.
- R8: With `RAM_FULL`=0, RAM covers 0000–7FFF. With `RAM_FULL`=1, RAM covers every address that no ROM claims. A memory or I/O cycle that hits nothing raises `void_hit`, and `void_data` then reads 0x00.
- R9: Ports F0–F3 select the timer. Ports F4–F5 select the main console. Ports F6–F7 select the alternate console. A read of port FF, and any access to another port, is an I/O miss.
- R10: During a memory cycle exactly one of `sel_ram`, `sel_boot`, `sel_mon` and `mem_miss` is high. With no cycle, none of them is high and `rom_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | input | 1 | Memory cycle in progress |
| mem_addr | input | 16 | Memory address |
| io_req | input | 1 | I/O cycle in progress |
| io_we | input | 1 | I/O cycle is a write |
| io_addr | input | 8 | I/O port number |
| ctrl_wdata | input | 4 | Low data nibble of the I/O write |
| sel_ram | output | 1 | RAM select |
| sel_boot | output | 1 | Boot ROM select |
| sel_mon | output | 1 | Monitor ROM select |
| mem_miss | output | 1 | Memory cycle hits nothing |
| rom_addr | output | 12 | Address inside the ROM image |
| sel_timer | output | 1 | Interval timer select |
| sel_con_main | output | 1 | Main console serial select |
| sel_con_alt | output | 1 | Alternate console serial select |
| io_miss | output | 1 | I/O cycle hits nothing |
| void_hit | output | 1 | Some cycle hit nothing |
| void_data | output | 8 | Value returned for a cycle that hit nothing |
| boot_sel_n | output | 1 | Boot overlay enable, active low |
| startup_n | output | 1 | Low-range overlay enable, active low |
| latch_q | output | 8 | All control latch bits |

## Verification
A fixed sweep of the window edges (07FF/0800, 7FFF/8000, E7FF/E800, EFFF/F000, F7FF/F800) is repeated in each of the three overlay layouts. The sweep runs on a small-RAM instance and a full-RAM instance at the same time, which separates a wrong layout choice from a wrong RAM extent. Control writes target the two mode bits and also the unused bits. Writes to neighbouring ports test whether the inverted bit-number and value fields are decoded and qualified correctly. A full sweep of all 256 port numbers, with both reads and writes, separates the peripheral windows and the read-only miss at port FF. A pseudo-random mix of cycles then checks that the latch model and the design stay in step.

// File: rtl/bovl_pkg.sv
package bovl_pkg;

  typedef enum logic [1:0] {
    OVL_DUAL = 2'd0,
    OVL_HIGH = 2'd1,
    OVL_OFF  = 2'd2
  } ovl_mode_e;

  typedef struct packed {
    logic ram;
    logic boot;
    logic mon;
    logic miss;
  } mem_sel_t;

  typedef struct packed {
    logic tmr;
    logic con_main;
    logic con_alt;
    logic miss;
    logic ctrl_wr;
  } io_sel_t;

  function automatic logic in_win(input logic [31:0] a,
                                  input int unsigned lo,
                                  input int unsigned span);
    return (a >= lo) && (a < lo + span);
  endfunction

  function automatic ovl_mode_e ovl_mode(input logic boot_n, input logic su_n);
    if (boot_n)     return OVL_OFF;
    else if (su_n)  return OVL_HIGH;
    else            return OVL_DUAL;
  endfunction

endpackage

// File: rtl/bovl_ctrl_latch.sv
module bovl_ctrl_latch #(
  parameter int LATCH_BITS = 8,
  localparam int IDX_W = $clog2(LATCH_BITS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W:0]        wr_data,
  output logic [LATCH_BITS-1:0] q
);

  logic [IDX_W-1:0] tgt_idx;
  logic             tgt_val;

  // Both fields of the control byte arrive inverted.
  assign tgt_idx = ~wr_data[IDX_W-1:0];
  assign tgt_val = ~wr_data[IDX_W];

  for (genvar i = 0; i < LATCH_BITS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        q[i] <= 1'b0;
      else if (wr_en && (tgt_idx == IDX_W'(i)))
        q[i] <= tgt_val;
    end
  end

endmodule

// File: rtl/bovl_io_decode.sv
module bovl_io_decode
  import bovl_pkg::*;
#(
  parameter int          IO_W       = 8,
  parameter int unsigned TMR_BASE   = 'hF0,
  parameter int unsigned TMR_SPAN   = 4,
  parameter int unsigned CONA_BASE  = 'hF4,
  parameter int unsigned CONB_BASE  = 'hF6,
  parameter int unsigned CON_SPAN   = 2,
  parameter int unsigned CTRL_PORT  = 'hFF
) (
  input  logic            req,
  input  logic            we,
  input  logic [IO_W-1:0] addr,
  output io_sel_t         sel
);

  logic [31:0] a32;
  logic        hit_tmr, hit_a, hit_b, hit_ctrl;

  always_comb begin
    a32      = 32'(addr);
    hit_tmr  = in_win(a32, TMR_BASE,  TMR_SPAN);
    hit_a    = in_win(a32, CONA_BASE, CON_SPAN);
    hit_b    = in_win(a32, CONB_BASE, CON_SPAN);
    // The control port exists for writes only.
    hit_ctrl = we && (a32 == CTRL_PORT);

    sel.tmr      = req && hit_tmr;
    sel.con_main = req && hit_a;
    sel.con_alt  = req && hit_b;
    sel.ctrl_wr  = req && hit_ctrl;
    sel.miss     = req && !(hit_tmr || hit_a || hit_b || hit_ctrl);
  end

endmodule

// File: rtl/bovl_mem_decode.sv
module bovl_mem_decode
  import bovl_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          ROM_AW      = 12,
  parameter int unsigned BOOT_SIZE   = 'h800,
  parameter int unsigned BOOT_LO     = 'h0000,
  parameter int unsigned BOOT_HI     = 'hE800,
  parameter int unsigned MON_BASE    = 'hF800,
  parameter int unsigned MON_OFS     = 'h800,
  parameter int unsigned RAM_SMALL   = 'h8000,
  parameter bit          RAM_FULL    = 1'b0,
  localparam int         OFS_W       = $clog2(BOOT_SIZE)
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              boot_n,
  input  logic              su_n,
  output mem_sel_t          sel,
  output logic [ROM_AW-1:0] rom_addr
);

  logic [31:0] a32;
  logic        in_lo, in_hi, in_mon, boot_hit, ram_area;
  ovl_mode_e   mode;
  logic [ROM_AW-1:0] ofs;

  assign a32 = 32'(addr);
  assign ofs = ROM_AW'(addr[OFS_W-1:0]);

  if (RAM_FULL) begin : g_ram_full
    assign ram_area = 1'b1;
  end else begin : g_ram_small
    assign ram_area = in_win(a32, 0, RAM_SMALL);
  end

  always_comb begin
    in_lo  = in_win(a32, BOOT_LO, BOOT_SIZE);
    in_hi  = in_win(a32, BOOT_HI, BOOT_SIZE);
    in_mon = in_win(a32, MON_BASE, BOOT_SIZE);
    mode   = ovl_mode(boot_n, su_n);
    unique case (mode)
      OVL_DUAL: boot_hit = in_lo || in_hi;
      OVL_HIGH: boot_hit = in_hi;
      default:  boot_hit = 1'b0;
    endcase

    // Priority: monitor, then overlay, then RAM underneath.
    sel.mon  = req && in_mon;
    sel.boot = req && !in_mon && boot_hit;
    sel.ram  = req && !in_mon && !boot_hit && ram_area;
    sel.miss = req && !in_mon && !boot_hit && !ram_area;

    if (sel.mon)       rom_addr = ROM_AW'(MON_OFS) + ofs;
    else if (sel.boot) rom_addr = ofs;
    else               rom_addr = '0;
  end

endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
  import bovl_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          IO_W       = 8,
  parameter int          DATA_W     = 8,
  parameter int          ROM_AW     = 12,
  parameter int          LATCH_BITS = 8,
  parameter int          BOOT_BIT   = 3,
  parameter int          START_BIT  = 5,
  parameter bit          RAM_FULL   = 1'b0,
  parameter int unsigned CTRL_PORT  = 'hFF,
  parameter int unsigned FILL_VALUE = 'h00
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         mem_req,
  input  logic [ADDR_W-1:0]            mem_addr,
  input  logic                         io_req,
  input  logic                         io_we,
  input  logic [IO_W-1:0]              io_addr,
  input  logic [$clog2(LATCH_BITS):0]  ctrl_wdata,
  output logic                         sel_ram,
  output logic                         sel_boot,
  output logic                         sel_mon,
  output logic                         mem_miss,
  output logic [ROM_AW-1:0]            rom_addr,
  output logic                         sel_timer,
  output logic                         sel_con_main,
  output logic                         sel_con_alt,
  output logic                         io_miss,
  output logic                         void_hit,
  output logic [DATA_W-1:0]            void_data,
  output logic                         boot_sel_n,
  output logic                         startup_n,
  output logic [LATCH_BITS-1:0]        latch_q
);

  mem_sel_t msel;
  io_sel_t  isel;

  bovl_ctrl_latch #(.LATCH_BITS(LATCH_BITS)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (isel.ctrl_wr),
    .wr_data (ctrl_wdata),
    .q       (latch_q)
  );

  assign boot_sel_n = latch_q[BOOT_BIT];
  assign startup_n  = latch_q[START_BIT];

  bovl_io_decode #(.IO_W(IO_W), .CTRL_PORT(CTRL_PORT)) u_io (
    .req  (io_req),
    .we   (io_we),
    .addr (io_addr),
    .sel  (isel)
  );

  bovl_mem_decode #(
    .ADDR_W   (ADDR_W),
    .ROM_AW   (ROM_AW),
    .RAM_FULL (RAM_FULL)
  ) u_mem (
    .req      (mem_req),
    .addr     (mem_addr),
    .boot_n   (boot_sel_n),
    .su_n     (startup_n),
    .sel      (msel),
    .rom_addr (rom_addr)
  );

  assign sel_ram      = msel.ram;
  assign sel_boot     = msel.boot;
  assign sel_mon      = msel.mon;
  assign mem_miss     = msel.miss;
  assign sel_timer    = isel.tmr;
  assign sel_con_main = isel.con_main;
  assign sel_con_alt  = isel.con_alt;
  assign io_miss      = isel.miss;
  assign void_hit     = msel.miss || isel.miss;
  assign void_data    = void_hit ? DATA_W'(FILL_VALUE) : '0;

endmodule

// File: rtl/bovl_checker.sv
module bovl_checker #(
  parameter int          ADDR_W     = 16,
  parameter int          IO_W       = 8,
  parameter int          DATA_W     = 8,
  parameter int          ROM_AW     = 12,
  parameter int          LATCH_BITS = 8,
  parameter int unsigned CTRL_PORT  = 'hFF,
  parameter int unsigned FILL_VALUE = 'h00
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        mem_req,
  input logic [ADDR_W-1:0]           mem_addr,
  input logic                        io_req,
  input logic                        io_we,
  input logic [IO_W-1:0]             io_addr,
  input logic [$clog2(LATCH_BITS):0] ctrl_wdata,
  input logic                        sel_ram,
  input logic                        sel_boot,
  input logic                        sel_mon,
  input logic                        mem_miss,
  input logic [ROM_AW-1:0]           rom_addr,
  input logic                        sel_timer,
  input logic                        sel_con_main,
  input logic                        sel_con_alt,
  input logic                        io_miss,
  input logic                        void_hit,
  input logic [DATA_W-1:0]           void_data,
  input logic                        boot_sel_n,
  input logic [LATCH_BITS-1:0]       latch_q
);
  localparam int IDX_W = $clog2(LATCH_BITS);

  logic             ctrl_wr;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_val;
  assign ctrl_wr = io_req && io_we && (io_addr == IO_W'(CTRL_PORT));
  assign wr_idx  = ~ctrl_wdata[IDX_W-1:0];
  assign wr_val  = ~ctrl_wdata[IDX_W];

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (latch_q == '0)); // R1

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctrl_wr |=> $stable(latch_q)); // R2

  AST_LATCH_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> ($countones(latch_q ^ $past(latch_q)) <= 1)); // R2

  AST_LATCH_VALUE: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (latch_q[$past(wr_idx)] == $past(wr_val))); // R2

  AST_BOOT_OFF: assert property (@(posedge clk) disable iff (rst)
    (mem_req && boot_sel_n) |-> !sel_boot); // R6

  AST_MON_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (mem_req && (mem_addr >= ADDR_W'('hF800))) |->
      (sel_mon && (rom_addr == ROM_AW'('h800) + ROM_AW'(mem_addr[10:0])))); // R7

  AST_VOID_FILL: assert property (@(posedge clk) disable iff (rst)
    (mem_miss || io_miss) |-> (void_hit && (void_data == DATA_W'(FILL_VALUE)))); // R8

  AST_CTRL_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (io_req && !io_we && (io_addr == IO_W'(CTRL_PORT))) |->
      (io_miss && !sel_timer && !sel_con_main && !sel_con_alt)); // R9

  AST_MEM_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> $onehot({sel_ram, sel_boot, sel_mon, mem_miss})); // R10

  AST_MEM_IDLE: assert property (@(posedge clk) disable iff (rst)
    !mem_req |-> (!sel_ram && !sel_boot && !sel_mon && !mem_miss && rom_addr == '0)); // R10

endmodule

bind boot_overlay_decoder bovl_checker #(
  .ADDR_W(ADDR_W), .IO_W(IO_W), .DATA_W(DATA_W), .ROM_AW(ROM_AW),
  .LATCH_BITS(LATCH_BITS), .CTRL_PORT(CTRL_PORT), .FILL_VALUE(FILL_VALUE)
) u_bovl_chk (.*);

// File: tb/tb_boot_overlay_decoder.sv
module tb_boot_overlay_decoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mem_req = 1'b0;
  logic [15:0] mem_addr = '0;
  logic io_req = 1'b0, io_we = 1'b0;
  logic [7:0] io_addr = '0;
  logic [3:0] ctrl_wdata = '0;

  logic        o_ram[2], o_boot[2], o_mon[2], o_miss[2];
  logic [11:0] o_rom[2];
  logic        o_tmr[2], o_ca[2], o_cb[2], o_iomiss[2], o_void[2];
  logic [7:0]  o_vdata[2];
  logic        o_bsn[2], o_sun[2];
  logic [7:0]  o_latch[2];

  int n_chk = 0, n_fail = 0;
  bit [7:0] m_latch = '0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_overlay_decoder #(.RAM_FULL(1'b0)) dut (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
    .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .ctrl_wdata(ctrl_wdata),
    .sel_ram(o_ram[0]), .sel_boot(o_boot[0]), .sel_mon(o_mon[0]), .mem_miss(o_miss[0]),
    .rom_addr(o_rom[0]), .sel_timer(o_tmr[0]), .sel_con_main(o_ca[0]),
    .sel_con_alt(o_cb[0]), .io_miss(o_iomiss[0]), .void_hit(o_void[0]),
    .void_data(o_vdata[0]), .boot_sel_n(o_bsn[0]), .startup_n(o_sun[0]),
    .latch_q(o_latch[0]));

  boot_overlay_decoder #(.RAM_FULL(1'b1)) dut_big (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
    .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .ctrl_wdata(ctrl_wdata),
    .sel_ram(o_ram[1]), .sel_boot(o_boot[1]), .sel_mon(o_mon[1]), .mem_miss(o_miss[1]),
    .rom_addr(o_rom[1]), .sel_timer(o_tmr[1]), .sel_con_main(o_ca[1]),
    .sel_con_alt(o_cb[1]), .io_miss(o_iomiss[1]), .void_hit(o_void[1]),
    .void_data(o_vdata[1]), .boot_sel_n(o_bsn[1]), .startup_n(o_sun[1]),
    .latch_q(o_latch[1]));

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: one vector = one cycle.
  task automatic apply(input string tag, input bit mreq, input int ma,
                       input bit ireq, input bit iwe, input int ia, input int wd);
    bit e_r, e_b, e_m, e_x, e_t, e_a, e_c, e_im, e_ctl;
    int e_rom;
    @(negedge clk);
    mem_req = mreq; mem_addr = 16'(ma);
    io_req = ireq; io_we = iwe; io_addr = 8'(ia); ctrl_wdata = 4'(wd);
    #1;
    e_ctl = ireq && iwe && ia == 'hFF;
    e_t = ireq && ia >= 'hF0 && ia <= 'hF3;
    e_a = ireq && (ia == 'hF4 || ia == 'hF5);
    e_c = ireq && (ia == 'hF6 || ia == 'hF7);
    e_im = ireq && !e_t && !e_a && !e_c && !e_ctl;
    for (int k = 0; k < 2; k++) begin
      e_r = 0; e_b = 0; e_m = 0; e_x = 0; e_rom = 0;
      if (mreq) begin
        if (ma >= 'hF800) begin
          e_m = 1; e_rom = 'h800 + (ma % 'h800);
        end else if (m_latch[3] == 0 &&
                     ((ma >= 'hE800 && ma <= 'hEFFF) || (ma < 'h800 && m_latch[5] == 0))) begin
          e_b = 1; e_rom = ma % 'h800;
        end else if (k == 1 || ma <= 'h7FFF) e_r = 1;
        else e_x = 1;
      end
      chk(tag, k ? "mem sel big" : "mem sel small",
          {o_ram[k], o_boot[k], o_mon[k], o_miss[k]}, {e_r, e_b, e_m, e_x});
      chk(tag, "rom_addr", o_rom[k], e_rom);
      chk(tag, "io sel", {o_tmr[k], o_ca[k], o_cb[k], o_iomiss[k]}, {e_t, e_a, e_c, e_im});
      chk(tag, "void", {o_void[k], o_vdata[k]}, {(e_x || e_im), 8'h00});
      chk("R3", "latch", {o_latch[k], o_bsn[k], o_sun[k]}, {m_latch, m_latch[3], m_latch[5]});
    end
    if (e_ctl) m_latch[(~wd) & 7] = ~wd[3];
  endtask

  task automatic latch_wr(input string tag, input int bitn, input bit val);
    apply(tag, 0, 0, 1, 1, 'hFF, ((val ? 0 : 1) << 3) | ((~bitn) & 7));
  endtask

  task automatic sweep(input string tag);
    int pts[12] = '{'h0000, 'h07FF, 'h0800, 'h7FFF, 'h8000, 'hE7FF,
                    'hE800, 'hEFFF, 'hF000, 'hF7FF, 'hF800, 'hFFFF};
    foreach (pts[i]) apply(tag, 1, pts[i], 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit [15:0] lfsr = 16'hACE1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    apply("R1", 0, 0, 0, 0, 0, 0);            // R1 reset state
    sweep("R4");                               // R4 dual overlay after reset
    apply("R10", 0, 'hF900, 0, 0, 0, 0);       // R10 idle cycle selects nothing
    latch_wr("R2", 5, 1);                      // R2 start-up high
    sweep("R5");                               // R5 high-only
    latch_wr("R2", 3, 1);                      // boot-select high
    sweep("R6");                               // R6 overlay off
    sweep("R7");                               // R7 monitor independent of latch
    latch_wr("R2", 3, 0);
    latch_wr("R2", 5, 0);
    sweep("R4");
    for (int b = 0; b < 8; b++) latch_wr("R3", b, 1);   // R3 every bit visible
    for (int b = 0; b < 8; b++) latch_wr("R3", b, 0);
    for (int p = 0; p < 256; p++) apply("R9", 0, 0, 1, 0, p, 0);   // R9 reads
    for (int p = 0; p < 256; p++) apply("R2", 0, 0, 1, 1, p, 0);   // R2 only FF writes count
    apply("R8", 1, 'hF000, 1, 0, 'h10, 0);     // R8 void read in both spaces
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] == 4'h0) apply("R2", 0, 0, 1, 1, 'hFF, lfsr[11:8]);
      else apply("R10", lfsr[4], lfsr, lfsr[5], 0, {4'hF, lfsr[9:6]}, 0);
    end
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    m_latch = '0;
    apply("R1", 1, 'h0100, 0, 0, 0, 0);        // R1 reset restores dual overlay
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule